// File: doc/BRIEF.md
# Asymmetric Conversion Clock Prescaler

This block derives a slow conversion clock from the fast system clock for an analog-to-digital sequencer. The high and low phases are set separately. A 5-bit field gives the number of system clocks in the high phase, less one. A 3-bit field gives the number in the low phase, less one. The duty cycle can therefore be asymmetric. For example, settings of 11 and 7 give 12 clocks high and 8 clocks low. That is a 20-clock period, or 2.0 MHz from a 40 MHz system clock.

The block also drives a one-cycle strobe when the conversion clock rises and another when it falls. Downstream timing logic can count conversion-clock cycles with these strobes instead of detecting edges itself. A legacy prescaler-add input is accepted so that older settings software still works, but it has no effect on the timing.

Phase settings are taken at period boundaries only, so a change never shortens or glitches a phase that is in progress. A period here is a low phase followed by a high phase. An enable input freezes the generator in place.

Top module: `convclk_gen`

## Requirements
- R1: With enable held high, the conversion clock stays high for exactly `hi_len + 1` system clocks, for every `hi_len` value from 0 to 31.
- R2: With enable held high, the conversion clock stays low for exactly `lo_len + 1` system clocks, for every `lo_len` value from 0 to 7.
- R3: The phase counter never passes the length of the current phase, and one full period lasts `(hi_len + 1) + (lo_len + 1)` clocks; settings 11 and 7 give 20 clocks.
- R4: The phase lengths are captured while reset is held and on the last cycle of each high phase. Changes made at any other time first take effect in the next period.
- R5: While reset is high, `conv_clk`, `rise_stb` and `fall_stb` are low. The first cycle after reset is the first cycle of a low phase, and that phase lasts `lo_len + 1` clocks.
- R6: While `en` is low, the level and the phase position are frozen and both strobes are low. The phase ends after the remaining enabled cycles once `en` returns high.
- R7: `rise_stb` is high for exactly one clock, which is the first clock in which `conv_clk` is high. It is low at all other times.
- R8: `fall_stb` is high for exactly one clock, which is the first low clock that follows a high phase. It is low at all other times, including the first low phase after reset.
- R9: The `legacy_add` input has no effect on the level or the strobes.
- R10: With both lengths at 0, the conversion clock toggles on every system clock: one clock high and one clock low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; low freezes the generator |
| hi_len | input | 5 | High-phase length minus one, in system clocks |
| lo_len | input | 3 | Low-phase length minus one, in system clocks |
| legacy_add | input | 1 | Legacy prescaler-add bit; ignored |
| conv_clk | output | 1 | Conversion clock level |
| rise_stb | output | 1 | One-clock strobe on the first high cycle |
| fall_stb | output | 1 | One-clock strobe on the first low cycle after a high phase |

## Verification
Every output comes from a register, so any change to the inputs shows up at the ports one system clock later. After reset is released the state is visible at once, and that sample counts as the first low cycle. The bench drives its inputs and samples the outputs on falling clock edges. It measures each phase by counting consecutive samples at one level, so sample k reflects k-1 rising edges after the phase began. Strobes are checked on the first sample of each phase and must be absent on every later sample of it. Every combination of the two length fields is measured, together with changes to the fields in the middle of a period, enable pauses and the legacy bit.

// File: rtl/convclk_pkg.sv
package convclk_pkg;

    localparam int HI_FIELD_W = 5;
    localparam int LO_FIELD_W = 3;
    localparam int CNT_W      = (HI_FIELD_W > LO_FIELD_W) ? HI_FIELD_W : LO_FIELD_W;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic [HI_FIELD_W-1:0] hi;
        logic [LO_FIELD_W-1:0] lo;
    } phase_cfg_t;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } clk_out_t;

    // Terminal count of the phase currently running.
    function automatic logic [CNT_W-1:0] phase_limit(input phase_cfg_t cfg, input phase_e ph);
        logic [CNT_W-1:0] lim;
        if (ph == PH_HIGH)
            lim = CNT_W'(cfg.hi);
        else
            lim = CNT_W'(cfg.lo);
        return lim;
    endfunction

endpackage

// File: rtl/convclk_cfg_latch.sv
module convclk_cfg_latch
    import convclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  phase_cfg_t cfg_in,
    output phase_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst || load)
            cfg_q <= cfg_in;
    end

endmodule

// File: rtl/convclk_phase_ctr.sv
module convclk_phase_ctr
    import convclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             term,
    output logic [CNT_W-1:0] cnt
);

    assign term = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (en) begin
            if (term)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    // R3: the position never runs past the phase length
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit)
        else $error("phase counter beyond limit");

    // R6: a paused counter does not move
    a_r6_cnt_frozen: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt))
        else $error("phase counter moved while paused");

endmodule

// File: rtl/convclk_edge_gen.sv
module convclk_edge_gen
    import convclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     term,
    output clk_out_t out_q
);

    logic flip;
    assign flip = en & term;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.rise <= flip & ~out_q.level;
            out_q.fall <= flip &  out_q.level;
            if (flip)
                out_q.level <= ~out_q.level;
        end
    end

    // R5: reset leaves the clock and both strobes low
    a_r5_reset_state: assert property (@(posedge clk)
        rst |=> (!out_q.level && !out_q.rise && !out_q.fall))
        else $error("outputs not cleared by reset");

    // R6: level held and strobes quiet while paused
    a_r6_hold_level: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(out_q.level) && !out_q.rise && !out_q.fall))
        else $error("level moved while paused");

    // R7: rise strobe only on the first high cycle
    a_r7_rise_on_edge: assert property (@(posedge clk) disable iff (rst)
        out_q.rise |-> (out_q.level && !$past(out_q.level)))
        else $error("rise strobe misplaced");

    // R8: fall strobe only on the first low cycle
    a_r8_fall_on_edge: assert property (@(posedge clk) disable iff (rst)
        out_q.fall |-> (!out_q.level && $past(out_q.level)))
        else $error("fall strobe misplaced");

    // R7, R8: the two strobes never overlap
    a_r7_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_q.rise && out_q.fall))
        else $error("both strobes high");

endmodule

// File: rtl/convclk_gen.sv
module convclk_gen
    import convclk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic [HI_FIELD_W-1:0] hi_len,
    input  logic [LO_FIELD_W-1:0] lo_len,
    input  logic                  legacy_add,
    output logic                  conv_clk,
    output logic                  rise_stb,
    output logic                  fall_stb
);

    phase_cfg_t       cfg_in;
    phase_cfg_t       cfg_q;
    clk_out_t         out_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;
    logic             term;
    logic             load;
    logic             legacy_unused;

    // Kept on the port list for settings compatibility only.
    assign legacy_unused = legacy_add;

    assign cfg_in.hi = hi_len;
    assign cfg_in.lo = lo_len;

    // A period is a low phase then a high phase; its last cycle takes new settings.
    assign load  = en & term & out_q.level;
    assign limit = phase_limit(cfg_q, phase_e'(out_q.level));

    convclk_cfg_latch u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    convclk_phase_ctr u_ctr (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .limit (limit),
        .term  (term),
        .cnt   (cnt)
    );

    convclk_edge_gen u_edge (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .term  (term),
        .out_q (out_q)
    );

    assign conv_clk = out_q.level;
    assign rise_stb = out_q.rise;
    assign fall_stb = out_q.fall;

    // R4: settings in use change only at a period boundary
    a_r4_cfg_boundary: assert property (@(posedge clk) disable iff (rst)
        (cfg_q != $past(cfg_q)) |-> ($past(out_q.level) && !out_q.level))
        else $error("settings changed inside a period");

endmodule

// File: tb/convclk_gen_test.sv
module convclk_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic [4:0] hi_len = '0;
    logic [2:0] lo_len = '0;
    logic       legacy_add = 1'b0;
    logic       conv_clk;
    logic       rise_stb;
    logic       fall_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    convclk_gen uut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .hi_len     (hi_len),
        .lo_len     (lo_len),
        .legacy_add (legacy_add),
        .conv_clk   (conv_clk),
        .rise_stb   (rise_stb),
        .fall_stb   (fall_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_reset(input int h, input int l);
        @(negedge clk);
        rst = 1'b1; en = 1'b1;
        hi_len = 5'(h); lo_len = 3'(l);
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Counts samples at level lvl; checks strobes on first and later samples.
    task automatic run_len(input logic lvl, output int n, output logic first_stb, output logic stray);
        n = 0; stray = 1'b0;
        first_stb = lvl ? rise_stb : fall_stb;
        while (conv_clk === lvl && n < 200) begin
            if (n == 0 && (lvl ? fall_stb : rise_stb)) stray = 1'b1;
            if (n > 0 && (rise_stb || fall_stb)) stray = 1'b1;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic test_reset_state();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(conv_clk == 1'b0, "R5 level in reset", int'(conv_clk), 0);
        chk(!rise_stb && !fall_stb, "R5 strobes in reset", int'({rise_stb, fall_stb}), 0);
    endtask

    task automatic test_all_lengths();
        int n; logic fs; logic st;
        for (int h = 0; h < 32; h++) begin
            for (int l = 0; l < 8; l++) begin
                apply_reset(h, l);
                run_len(1'b0, n, fs, st);
                chk(n == l + 1, "R5 first low phase", n, l + 1);
                chk(!fs && !st, "R8 no fall after reset", int'(fs), 0);
                run_len(1'b1, n, fs, st);
                chk(n == h + 1, "R1 high length", n, h + 1);
                chk(fs && !st, "R7 rise strobe", int'({fs, st}), 2);
                run_len(1'b0, n, fs, st);
                chk(n == l + 1, "R2 low length", n, l + 1);
                chk(fs && !st, "R8 fall strobe", int'({fs, st}), 2);
            end
        end
    endtask

    task automatic test_period();
        int nl; int nh; logic fs; logic st;
        apply_reset(11, 7);
        run_len(1'b0, nl, fs, st);
        run_len(1'b1, nh, fs, st);
        chk(nl + nh == 20, "R3 period 11/7", nl + nh, 20);
    endtask

    task automatic test_boundary_sampling();
        int n; logic fs; logic st;
        apply_reset(3, 2);
        hi_len = 5'd9; lo_len = 3'd5;
        run_len(1'b0, n, fs, st);
        chk(n == 3, "R4 low keeps old setting", n, 3);
        run_len(1'b1, n, fs, st);
        chk(n == 4, "R4 high keeps old setting", n, 4);
        run_len(1'b0, n, fs, st);
        chk(n == 6, "R4 next low uses new", n, 6);
        run_len(1'b1, n, fs, st);
        chk(n == 10, "R4 next high uses new", n, 10);
    endtask

    task automatic test_enable_pause();
        int n; logic fs; logic st;
        apply_reset(4, 3);
        @(negedge clk);
        en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(conv_clk == 1'b0 && !rise_stb && !fall_stb, "R6 frozen while paused",
                int'({conv_clk, rise_stb, fall_stb}), 0);
        end
        en = 1'b1;
        run_len(1'b0, n, fs, st);
        chk(n == 3, "R6 remaining low cycles", n, 3);
        run_len(1'b1, n, fs, st);
        chk(n == 5, "R6 high after pause", n, 5);
    endtask

    task automatic test_minimum();
        apply_reset(0, 0);
        for (int i = 0; i < 6; i++) begin
            chk(conv_clk == 1'(i % 2), "R10 toggle every clock", int'(conv_clk), i % 2);
            if (i > 0)
                chk(rise_stb == 1'(i % 2) && fall_stb == 1'((i + 1) % 2), "R10 strobe each clock",
                    int'({rise_stb, fall_stb}), (i % 2) ? 2 : 1);
            @(negedge clk);
        end
    endtask

    task automatic test_legacy();
        int n; logic fs; logic st;
        int hs[4] = '{11, 7, 0, 31};
        int ls[4] = '{7, 7, 0, 7};
        for (int k = 0; k < 4; k++) begin
            apply_reset(hs[k], ls[k]);
            legacy_add = 1'b1;
            run_len(1'b0, n, fs, st);
            chk(n == ls[k] + 1, "R9 low with legacy bit", n, ls[k] + 1);
            legacy_add = 1'b0;
            run_len(1'b1, n, fs, st);
            chk(n == hs[k] + 1 && fs && !st, "R9 high with legacy bit", n, hs[k] + 1);
            legacy_add = 1'b1;
        end
        legacy_add = 1'b0;
    endtask

    initial begin
        test_reset_state();
        test_all_lengths();
        test_period();
        test_boundary_sampling();
        test_enable_pause();
        test_minimum();
        test_legacy();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule